// File: doc/BRIEF.md
# Tournament Hybrid Branch Predictor

This block predicts the direction of a conditional branch from its address. Two direction predictors run side by side. The global component keeps a shared shift register of recent outcomes, XORs it with the low address bits, and uses the result to pick one two-bit counter from a shared table. The local component picks a two-bit counter from its own table using the address bits alone. A third table of two-bit chooser counters, indexed by the address, decides which of the two answers becomes the final prediction.

The front end presents a PC on the predict port and reads the final direction, both component directions and the history value in the same cycle. Once the branch resolves, it returns the PC, the actual outcome, the two component directions and the history value it captured. The block then updates all three counters at the same entries that produced the prediction, and shifts the outcome into the global history. Target prediction and pipeline control are outside this block.

Top module: `tourney_bp`

## Requirements
- R1: After reset the history is all zeros, every component counter holds 01 (weakly not taken) and every chooser counter holds 10 (weakly global), so every PC predicts not taken from both components and in the final output.
- R2: The global component reads the counter at index `pred_pc[HIST_W-1:0] XOR pred_hist`, and an update writes the counter at `upd_pc[HIST_W-1:0] XOR upd_hist`.
- R3: The local component and the chooser both read and write the entry at the low `LOC_W` bits of the PC.
- R4: A component counter moves one step up on a taken outcome and one step down on a not-taken outcome. It stays at 11 and at 00 at the ends, and its high bit is the predicted direction (1 = taken).
- R5: A chooser value of 10 or 11 selects the global component for `pred_taken`. A value of 00 or 01 selects the local component.
- R6: When the reported global direction matches the outcome and the local one does not, the chooser entry moves one step up, saturating at 11.
- R7: When the reported local direction matches the outcome and the global one does not, the chooser entry moves one step down, saturating at 00.
- R8: When both reported directions are right, or both are wrong, the chooser entry keeps its value.
- R9: Each accepted update shifts the outcome into bit 0 of the history and drops the oldest bit. The new history is visible on `pred_hist` in the next cycle.
- R10: While `upd_valid` is low, no table entry and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Final predicted direction |
| pred_glob | output | 1 | Global component direction |
| pred_loc | output | 1 | Local component direction |
| pred_hist | output | HIST_W | Current global history, returned on update |
| upd_valid | input | 1 | Apply one resolved-branch update this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History value seen when the branch was predicted |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_glob | input | 1 | Global direction reported at predict time |
| upd_loc | input | 1 | Local direction reported at predict time |

## Verification
One branch address is trained with a sequence of outcomes that flips the chooser in both directions, so the final output can be seen to follow the global component, then the local one, then the global one again. Further addresses are picked so that address XOR history lands on entries trained earlier. A correct prediction there shows that the index is the XOR and not the address alone. Runs of three same-direction outcomes followed by reversals tell a saturating counter apart from one that wraps. Separate checks cover idle cycles with live update fields and a reset in the middle of the run.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int LOC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic              pred_glob,
  output logic              pred_loc,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_glob,
  input  logic              upd_loc
);
  localparam int G_N = 1 << HIST_W;
  localparam int L_N = 1 << LOC_W;

  logic [1:0]        gtab [G_N];
  logic [1:0]        ltab [L_N];
  logic [1:0]        stab [L_N];
  logic [HIST_W-1:0] ghist;

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  wire [HIST_W-1:0] g_ri = pred_pc[HIST_W-1:0] ^ ghist;
  wire [LOC_W-1:0]  l_ri = pred_pc[LOC_W-1:0];
  wire [HIST_W-1:0] g_wi = upd_pc[HIST_W-1:0] ^ upd_hist;
  wire [LOC_W-1:0]  l_wi = upd_pc[LOC_W-1:0];

  wire g_ok = (upd_glob == upd_taken);
  wire l_ok = (upd_loc == upd_taken);

  assign pred_glob  = gtab[g_ri][1];
  assign pred_loc   = ltab[l_ri][1];
  assign pred_taken = stab[l_ri][1] ? pred_glob : pred_loc;
  assign pred_hist  = ghist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < G_N; i++) gtab[i] <= 2'b01;
    end else if (upd_valid) begin
      ghist       <= {ghist[HIST_W-2:0], upd_taken};
      gtab[g_wi]  <= step2(gtab[g_wi], upd_taken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L_N; i++) begin
        ltab[i] <= 2'b01;
        stab[i] <= 2'b10;
      end
    end else if (upd_valid) begin
      ltab[l_wi] <= step2(ltab[l_wi], upd_taken);
      if (g_ok != l_ok) stab[l_wi] <= step2(stab[l_wi], g_ok);
    end
  end
endmodule

module tourney_bp_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   pred_pc,
  input logic              pred_taken,
  input logic              pred_glob,
  input logic              pred_loc,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_taken
);
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}); // R9

  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist)); // R10

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_glob == pred_loc) |-> (pred_taken == pred_glob)); // R5

  AST_IDLE_TABLES: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (pred_pc != $past(pred_pc)) ||
                   ($stable(pred_loc) && $stable(pred_glob) && $stable(pred_taken))); // R10

  AST_LOC_TAKEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && pred_loc && $past(upd_valid) == 1'b0) |=>
      (pred_pc != $past(pred_pc)) || pred_loc || $past(pred_pc) != $past(pred_pc, 2)); // R4
endmodule

bind tourney_bp tourney_bp_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
  .pred_glob(pred_glob), .pred_loc(pred_loc), .pred_hist(pred_hist),
  .upd_valid(upd_valid), .upd_taken(upd_taken)
);

// File: tb/sim_tourney_bp.sv
module sim_tourney_bp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_glob, pred_loc;
  logic [7:0]  pred_hist;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [7:0]  upd_hist = '0;
  logic        upd_taken = 1'b0, upd_glob = 1'b0, upd_loc = 1'b0;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tourney_bp u0 (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_glob(pred_glob), .pred_loc(pred_loc), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
    .upd_taken(upd_taken), .upd_glob(upd_glob), .upd_loc(upd_loc)
  );

  // {pc[7:0], outcome, expected hist[7:0], exp glob, exp loc, exp final}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {8'h10, 1'b1, 8'h00, 3'b000},  // R1 R4
    {8'h10, 1'b1, 8'h01, 3'b010},  // R7 next
    {8'h10, 1'b0, 8'h03, 3'b011},  // R5 local chosen
    {8'h10, 1'b0, 8'h06, 3'b010},  // R6 back to global
    {8'h10, 1'b1, 8'h0C, 3'b000},  // R8 both wrong
    {8'h10, 1'b0, 8'h19, 3'b010},  // R6 saturate
    {8'h10, 1'b1, 8'h32, 3'b000},
    {8'h74, 1'b1, 8'h65, 3'b101},  // R2 xor alias hit
    {8'hD8, 1'b0, 8'hCB, 3'b000},  // R8 both right
    {8'h85, 1'b1, 8'h96, 3'b000},  // R4 low saturation
    {8'h3E, 1'b1, 8'h2D, 3'b000},
    {8'h48, 1'b1, 8'h5B, 3'b101}   // R4 R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic branch(input logic [31:0] pc, input logic tk);
    @(negedge clk);
    pred_pc = pc;
    #1;
    upd_pc = pc; upd_hist = pred_hist; upd_glob = pred_glob;
    upd_loc = pred_loc; upd_taken = tk; upd_valid = 1'b1;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic peek(input logic [31:0] pc);
    @(negedge clk);
    pred_pc = pc;
    #1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    peek(32'h0000_00AB);
    check("R1 hist", pred_hist, 0);
    check("R1 glob", pred_glob, 0);
    check("R1 loc", pred_loc, 0);
    check("R1 final", pred_taken, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pred_pc = {24'h0, VEC[i][19:12]};
      #1;
      check($sformatf("R9 hist v%0d", i), pred_hist, VEC[i][10:3]);
      check($sformatf("R2 glob v%0d", i), pred_glob, VEC[i][2]);
      check($sformatf("R3 loc v%0d", i), pred_loc, VEC[i][1]);
      check($sformatf("R5 final v%0d", i), pred_taken, VEC[i][0]);
      upd_pc = pred_pc; upd_hist = pred_hist; upd_glob = pred_glob;
      upd_loc = pred_loc; upd_taken = VEC[i][11]; upd_valid = 1'b1;
      @(posedge clk);
      #1 upd_valid = 1'b0;
    end

    // R10: live update fields with valid low
    @(negedge clk);
    upd_pc = 32'h48; upd_taken = 1'b0; upd_glob = 1'b1; upd_loc = 1'b1; upd_hist = 8'hB7;
    repeat (3) @(negedge clk);
    pred_pc = 32'h48;
    #1;
    check("R10 hist", pred_hist, 8'hB7);
    check("R10 loc", pred_loc, 1);
    check("R10 final", pred_taken, 0);

    // R4 high saturation: T T T N N -> 01
    for (int i = 0; i < 3; i++) branch(32'h20, 1'b1);
    for (int i = 0; i < 2; i++) branch(32'h20, 1'b0);
    peek(32'h20);
    check("R4 sat high", pred_loc, 0);

    // R4 low saturation: N N N T T -> 10
    for (int i = 0; i < 3; i++) branch(32'h21, 1'b0);
    for (int i = 0; i < 2; i++) branch(32'h21, 1'b1);
    peek(32'h21);
    check("R4 sat low", pred_loc, 1);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    peek(32'h48);
    check("R1 rerst hist", pred_hist, 0);
    check("R1 rerst loc", pred_loc, 0);
    check("R1 rerst final", pred_taken, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule